// File: doc/BRIEF.md
# SPI Control Register Bank with Write Lock

This block is the device side of a 16-bit serial control link. It samples SPI clock, chip select and data-in with the system clock and assembles each frame. It accepts a frame only when the whole 16-bit word has even parity. It then decodes a read/write flag and a 6-bit address and either returns or updates one of a small set of 8-bit control registers. On the data-out line the block sends a status byte followed by the current contents of the addressed register. The register contents are also driven in parallel toward the functions they configure.

One control register carries a 3-bit lock field. Until the unlock code is written there, every other control register refuses writes. Power-on reset and the sleep input both return all registers, the lock and the sticky error flag to their defaults. The driver-off input only drops the driver enable and leaves everything stored alone. A chip-select window that ends with anything other than exactly 16 SPI clocks is thrown away.

Top module: `spi_ctrl_regfile`

## Requirements
- R1: A frame is 16 bits sent MSB first while spi_cs_n is low: bit 15 is the direction (1 = read, 0 = write), bits 14:9 the address, bit 8 the parity bit and bits 7:0 the data. spi_mosi is taken on the rising SPI clock, spi_miso changes after the falling SPI clock, and its first bit is valid once spi_cs_n has fallen.
- R2: A frame whose 16 bits hold an odd number of ones changes no register and no lock state.
- R3: spi_miso carries, MSB first, the status byte {error flag, locked, 6'b0} captured when spi_cs_n falls, then the addressed register's value. It is 0 while spi_cs_n is high.
- R4: Address 0x00 is the read-only status byte. Control registers 1 to 6 sit at 0x03 to 0x08, so control 3 is at 0x05. Any other address reads 0x00 and ignores writes.
- R5: Bits 2:0 of control 1 (0x03) form the lock field. Writing 3'b011 unlocks, writing 3'b110 locks, and other values keep the lock state. Control 1 is always writable. While locked, writes to 0x04 to 0x08 are ignored.
- R6: The status error flag (bit 7) is set by a complete 16-bit frame with bad parity. It stays set until a read of 0x00 with good parity ends, and that read still returns the flag as set.
- R7: A chip-select window with fewer or more than 16 SPI clocks changes no register, no lock state and no error flag.
- R8: While sleep is high, and after it falls, all control registers hold their reset values, the bank is locked and the error flag is clear.
- R9: drv_en is the inverse of (drv_off or sleep). drv_off changes no stored value and does not stop SPI access.
- R10: After power-on reset every control register reads 0x00 and the status byte is 0x40 (locked, no error).
- R11: ctrl_q[8*i+7:8*i] always shows control register i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep | input | 1 | Sleep request; forces the defaults |
| drv_off | input | 1 | Driver disable; affects drv_en only |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| drv_en | output | 1 | Output driver enable |
| ctrl_q | output | 48 | Parallel contents of control registers 1 to 6 |

## Verification
Every one of the 64 addresses is read after reset, written with an address-derived byte while unlocked, read back, and then written again while locked. This separates decode errors, wrong reset values and holes in the lock. The lock field is driven with the unlock code, the lock code and a neutral code to show that only the two codes move the lock state. Frames with a single flipped parity bit, frames cut to 10 clocks and frames stretched to 17 clocks show that each is rejected and that only the full-length bad frame raises the error flag. Sleep and driver-off pulses are applied on top of non-default contents so that a reset becomes visible and a wrongly triggered one is caught.

// File: rtl/spi_ctrl_regfile.sv
module spi_ctrl_regfile #(
  parameter int NUM_CTRL = 6,
  parameter logic [5:0] CTRL_BASE = 6'h03,
  parameter logic [5:0] STAT_ADDR = 6'h00,
  parameter logic [2:0] UNLOCK_CODE = 3'b011,
  parameter logic [2:0] LOCK_CODE = 3'b110,
  parameter logic [8*NUM_CTRL-1:0] CTRL_RST = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sleep,
  input  logic                  drv_off,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  drv_en,
  output logic [8*NUM_CTRL-1:0] ctrl_q
);
  localparam int FRAME_BITS = 16;
  localparam int CW = $clog2(FRAME_BITS) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire sclk_fall = ~sclk_s[1] & sclk_s[2];
  wire cs_fall   = ~cs_s[1] & cs_s[2];
  wire cs_rise   = cs_s[1] & ~cs_s[2];
  wire active    = ~cs_s[1];

  logic [15:0]   rx;
  logic [CW-1:0] nrise, nfall;
  logic [5:0]    addr_q;
  logic [7:0]    stat_cap, rd_byte;
  logic [7:0]    regs [NUM_CTRL];
  logic          locked, ferr;

  wire [7:0] status = {ferr, locked, 6'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx <= '0; nrise <= '0; nfall <= '0; addr_q <= '0; stat_cap <= '0;
    end else if (sleep) begin
      rx <= '0; nrise <= '0; nfall <= '0; addr_q <= '0; stat_cap <= '0;
    end else if (cs_fall) begin
      rx <= '0; nrise <= '0; nfall <= '0;
      stat_cap <= status;
    end else if (active) begin
      if (sclk_rise) begin
        rx <= {rx[14:0], mosi_s[1]};
        if (nrise != CNT_MAX) nrise <= nrise + 1'b1;
        if (nrise == CW'(6)) addr_q <= {rx[4:0], mosi_s[1]};
      end
      if (sclk_fall && nfall != CNT_MAX) nfall <= nfall + 1'b1;
    end

  wire       f_rd   = rx[15];
  wire [5:0] f_addr = rx[14:9];
  wire [7:0] f_data = rx[7:0];
  wire       f_full = cs_rise && nrise == CNT_FULL;
  wire       f_ok   = f_full && ~^rx;
  wire       f_bad  = f_full && ^rx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || sleep) begin
      for (int i = 0; i < NUM_CTRL; i++) regs[i] <= CTRL_RST[8*i +: 8];
      locked <= 1'b1;
      ferr   <= 1'b0;
    end else if (f_bad) begin
      ferr <= 1'b1;
    end else if (f_ok) begin
      if (f_rd) begin
        if (f_addr == STAT_ADDR) ferr <= 1'b0;
      end else begin
        for (int i = 0; i < NUM_CTRL; i++)
          if (f_addr == CTRL_BASE + 6'(i) && (i == 0 || !locked)) regs[i] <= f_data;
        if (f_addr == CTRL_BASE) begin
          if (f_data[2:0] == UNLOCK_CODE) locked <= 1'b0;
          else if (f_data[2:0] == LOCK_CODE) locked <= 1'b1;
        end
      end
    end

  always_comb begin
    rd_byte = '0;
    if (addr_q == STAT_ADDR) rd_byte = status;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr_q == CTRL_BASE + 6'(i)) rd_byte = regs[i];
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_out
    assign ctrl_q[8*g +: 8] = regs[g];
  end

  wire [2:0] bit_sel = 3'd7 - nfall[2:0];
  assign spi_miso = active && nfall < CNT_FULL &&
                    (nfall < CW'(8) ? stat_cap[bit_sel] : rd_byte[bit_sel]);
  assign drv_en = ~drv_off & ~sleep;

  a_r7_partial_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && nrise != CNT_FULL && !sleep) |=> $stable(ctrl_q));
  a_r2_bad_parity_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && nrise == CNT_FULL && ^rx && !sleep) |=> ($stable(ctrl_q) && $stable(locked) && ferr));
  a_r5_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !sleep) |=> $stable(ctrl_q[8*NUM_CTRL-1:8]));
  a_r8_sleep_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (ctrl_q == CTRL_RST && locked && !ferr));
  a_r3_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s[1] |-> !spi_miso);
  a_r6_error_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> $past(cs_rise));
endmodule

// File: tb/spi_ctrl_regfile_bench.sv
module spi_ctrl_regfile_bench;
  logic clk = 0, rst_n = 0, sleep = 0, drv_off = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, drv_en;
  logic [47:0] ctrl_q;
  int checks = 0, failures = 0;
  logic [7:0] m_reg [6];
  logic m_lock = 1, m_ferr = 0;

  always #10 clk = ~clk;

  spi_ctrl_regfile u_spi_ctrl_regfile (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .drv_off(drv_off),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .drv_en(drv_en), .ctrl_q(ctrl_q));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic rd, input logic [5:0] a, input logic [7:0] d);
    logic [15:0] f;
    f = {rd, a, 1'b0, d};
    f[8] = ^f;
    return f;
  endfunction

  function automatic logic [7:0] mread(input logic [5:0] a);
    if (a == 6'h00) return {m_ferr, m_lock, 6'b0};
    if (a >= 6'h03 && a <= 6'h08) return m_reg[int'(a) - 3];
    return 8'h00;
  endfunction

  function automatic logic [47:0] mvec();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = m_reg[i];
    return v;
  endfunction

  task automatic mreset();
    for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
    m_lock = 1; m_ferr = 0;
  endtask

  // R1 framing: bit 15 sent first, mosi set up before the rising SCLK, miso sampled just before it
  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rxw);
    rxw = '0;
    cs_n = 0; mosi = tx[15];
    wclk(10);
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) rxw[15-i] = miso;
      sclk = 1; wclk(8);
      sclk = 0; mosi = (i + 1 < 16) ? tx[14-i] : 1'b0;
      wclk(8);
    end
    cs_n = 1;
    wclk(10);
  endtask

  task automatic frame(input logic [15:0] f, input int nbits, input string tag);
    logic [15:0] r;
    logic [7:0] es, ed;
    es = {m_ferr, m_lock, 6'b0};
    ed = mread(f[14:9]);
    xfer(f, nbits, r);
    if (nbits == 16) begin
      chk(r[15:8] == es, {tag, " R3 status byte"}, 48'(r[15:8]), 48'(es));
      chk(r[7:0] == ed, {tag, " R3/R4 data byte"}, 48'(r[7:0]), 48'(ed));
      if (^f) m_ferr = 1;
      else if (f[15]) begin
        if (f[14:9] == 6'h00) m_ferr = 0;
      end else if (f[14:9] == 6'h03) begin
        m_reg[0] = f[7:0];
        if (f[2:0] == 3'b011) m_lock = 0;
        else if (f[2:0] == 3'b110) m_lock = 1;
      end else if (f[14:9] >= 6'h04 && f[14:9] <= 6'h08 && !m_lock)
        m_reg[int'(f[14:9]) - 3] = f[7:0];
    end
    chk(ctrl_q == mvec(), {tag, " R11 ctrl_q"}, ctrl_q, mvec());
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    frame(mk(1'b1, a, 8'h00), 16, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag);
    frame(mk(1'b0, a, d), 16, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mreset();
    wclk(5); rst_n = 1; wclk(5);
    chk(ctrl_q == 48'h0, "R10 reset ctrl_q", ctrl_q, 48'h0);
    chk(drv_en == 1'b1, "R9 drv_en idle", 48'(drv_en), 48'h1);
    chk(miso == 1'b0, "R3 miso idle", 48'(miso), 48'h0);
    // R10/R4: full address sweep after reset, ctrl3 at 0x05 reads 0x00
    for (int a = 0; a < 64; a++) rd(6'(a), "R10 reset read");
    // R5: locked after reset, writes to 0x04..0x08 dropped
    wr(6'h05, 8'h77, "R5 locked write");
    rd(6'h05, "R5 locked readback");
    wr(6'h03, 8'h03, "R5 unlock");
    // R4: write sweep with address-derived data while unlocked
    for (int a = 0; a < 64; a++) begin
      if (a == 3) continue;
      wr(6'(a), 8'(a * 29 + 7) ^ 8'h5A, "R4 write sweep");
    end
    for (int a = 0; a < 64; a++) rd(6'(a), "R4 readback sweep");
    // R5: neutral code keeps unlocked, lock code locks
    wr(6'h03, 8'h05, "R5 neutral code");
    wr(6'h06, 8'hC3, "R5 still unlocked");
    wr(6'h03, 8'h0E, "R5 lock code");
    for (int a = 4; a <= 8; a++) wr(6'(a), 8'hFF, "R5 locked sweep");
    wr(6'h03, 8'h01, "R5 neutral while locked");
    wr(6'h07, 8'h11, "R5 neutral keeps lock");
    wr(6'h03, 8'hF3, "R5 unlock upper bits");
    // R2/R6: flipped parity on a write
    frame(mk(1'b0, 6'h04, 8'h99) ^ 16'h0100, 16, "R2 bad parity write");
    rd(6'h04, "R2 value kept");
    frame(mk(1'b1, 6'h00, 8'h00) ^ 16'h0100, 16, "R6 bad parity status read");
    rd(6'h00, "R6 status read clears");
    rd(6'h00, "R6 cleared");
    // R2: bad parity on the lock register keeps the lock state
    frame(mk(1'b0, 6'h03, 8'h06) ^ 16'h0001, 16, "R2 bad parity lock");
    wr(6'h08, 8'h3C, "R2 lock state kept");
    rd(6'h00, "R6 clear again");
    // R7: short and long frames
    frame(mk(1'b0, 6'h05, 8'hE1), 10, "R7 short frame");
    frame(mk(1'b0, 6'h05, 8'hE1), 17, "R7 long frame");
    frame(mk(1'b0, 6'h03, 8'h06), 15, "R7 short lock frame");
    rd(6'h05, "R7 unchanged");
    rd(6'h00, "R7 no error flag");
    // R9: driver off keeps contents, SPI still usable
    drv_off = 1; wclk(3);
    chk(drv_en == 1'b0, "R9 drv_en off", 48'(drv_en), 48'h0);
    chk(ctrl_q == mvec(), "R9 contents kept", ctrl_q, mvec());
    wr(6'h06, 8'h5D, "R9 write with driver off");
    rd(6'h06, "R9 readback");
    drv_off = 0; wclk(3);
    chk(drv_en == 1'b1, "R9 drv_en back", 48'(drv_en), 48'h1);
    // R8: sleep resets everything
    frame(mk(1'b0, 6'h07, 8'h01) ^ 16'h0100, 16, "R8 set error before sleep");
    sleep = 1; wclk(4);
    mreset();
    chk(drv_en == 1'b0, "R8 drv_en asleep", 48'(drv_en), 48'h0);
    chk(ctrl_q == 48'h0, "R8 defaults while asleep", ctrl_q, 48'h0);
    sleep = 0; wclk(4);
    for (int a = 0; a < 10; a++) rd(6'(a), "R8 read after sleep");
    wr(6'h05, 8'h42, "R8 locked after sleep");
    rd(6'h05, "R8 ctrl3 default");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule